// File: doc/BRIEF.md
# Multi-State Logic Analyzer Trigger Sequencer

This block decides, sample by sample, whether a logic analyzer stores data and when it fires its trigger. A table of 16 programmable states drives it. Each state holds three enable masks over an incoming vector of match bits. One mask is for capture, one for hit and one for else. Each state also holds a control word with:
- an occurrence count;
- a branch target;
- start, stop and clear controls for two external timers;
- a trigger flag;
- a last-state mark.

The comparators, range checks, edge detectors and timers are upstream. Their results arrive as `match_i`.

Software loads the table while `arm_i` is low. Raising `arm_i` starts the sequence from state 0. Writes made while armed are dropped, so the table cannot change during a capture. On every valid sample the sequencer can do three things. It flags capture when the state's capture condition holds. It counts hits and moves to the next state on the programmed occurrence. When there is no hit but the else condition holds, it jumps to the else target. The run request to the analyzer controller is sticky until the block is disarmed.

Top module: `trig_seq`

## Requirements
- R1: While `rst_ni` is low, and after it is released with `arm_i` low, `state_o` is 0 and `run_o`, `capture_o` and all timer pulses are 0.
- R2: While `arm_i` is low, the sequencer holds state 0 with the hit count cleared and `run_o` low, and register writes are accepted. A write made while `arm_i` is high leaves the table unchanged.
- R3: On a cycle with `sample_valid_i` low, state and hit count do not change, and in the next cycle `capture_o` and all timer pulses are 0.
- R4: `capture_o` is high in the cycle after a valid sample whose match bits overlap the current state's capture mask. This holds regardless of the hit and else outcome.
- R5: Each valid sample that overlaps the hit mask adds one to the hit count. The sample that brings the count to the occurrence count (word bits 19:0, with 0 treated as 1) completes the state. On completion the count clears and the state index advances by one.
- R6: On the completing hit, for one cycle, the timer pulses follow the control word. Bits 25:24 stop timers 1:0, bits 27:26 clear them and bits 29:28 start them.
- R7: On the completing hit, `run_o` is set if the trigger flag (bit 30) is set or the state is a last state. Once set, it stays high until `arm_i` goes low or reset.
- R8: A state with bit 31 set, and state 15 in any case, is a last state. On completion it clears its count but keeps its index.
- R9: On a valid sample with no hit but with the else mask overlapping the match bits, the count clears and the state jumps to the index in bits 23:20. A hit takes priority over else.
- R10: An all-zero mask makes its condition false for every match value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| arm_i | input | 1 | High runs the sequence; low holds state 0 and opens the table for writes |
| wr_en_i | input | 1 | Table write strobe |
| wr_sel_i | input | 4 | State entry to write |
| wr_field_i | input | 2 | 0 control word, 1 capture mask, 2 hit mask, 3 else mask |
| wr_data_i | input | 32 | Write data; masks use the low MATCH_W bits |
| sample_valid_i | input | 1 | Sample strobe |
| match_i | input | MATCH_W | Match bits from upstream terms |
| capture_o | output | 1 | Store this sample (one cycle after it) |
| run_o | output | 1 | Sticky run request to the analyzer controller |
| tmr_start_o | output | 2 | Start pulses for timers 1:0 |
| tmr_stop_o | output | 2 | Stop pulses for timers 1:0 |
| tmr_clear_o | output | 2 | Clear pulses for timers 1:0 |
| state_o | output | 4 | Current state index |

## Verification
The checker watches properties that hold on every cycle. While disarmed, the block sits in state 0 with run low. An idle strobe freezes the state and silences capture and pulses. Capture and pulses only follow an armed valid sample. The state index moves only on a valid sample or a disarm, and run stays set while armed. Only the bench scenarios can show the counting itself: advancing on exactly the Nth hit, zero counts behaving as one, hit winning over else, branch targets, last-state holding, dropped armed writes and empty masks. All of these depend on the programmed table contents.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;
  localparam int STATE_W    = 4;
  localparam int NUM_STATES = 1 << STATE_W;
  localparam int CNT_W      = 20;
  localparam int WORD_W     = 32;
  localparam int NUM_TMR    = 2;
  localparam int NUM_COND   = 3;
  localparam int COND_CAP   = 0;
  localparam int COND_HIT   = 1;
  localparam int COND_ELSE  = 2;

  // msb..lsb matches the programmed word layout
  typedef struct packed {
    logic               last;
    logic               trig;
    logic [NUM_TMR-1:0] start;
    logic [NUM_TMR-1:0] clear;
    logic [NUM_TMR-1:0] stop;
    logic [STATE_W-1:0] else_idx;
    logic [CNT_W-1:0]   occ;
  } state_word_t;

  typedef enum logic [1:0] {
    FLD_CTRL = 2'd0,
    FLD_CAP  = 2'd1,
    FLD_HIT  = 2'd2,
    FLD_ELSE = 2'd3
  } field_e;
endpackage

// File: rtl/trig_seq_cond.sv
module trig_seq_cond #(
  parameter int MATCH_W  = 8,
  parameter int NUM_COND = 3
) (
  input  logic [NUM_COND-1:0][MATCH_W-1:0] mask_i,
  input  logic [MATCH_W-1:0]               match_i,
  output logic [NUM_COND-1:0]              cond_o
);
  for (genvar g = 0; g < NUM_COND; g++) begin : g_cond
    assign cond_o[g] = |(mask_i[g] & match_i);
  end
endmodule

// File: rtl/trig_seq_table.sv
module trig_seq_table
  import trig_seq_pkg::*;
#(
  parameter int MATCH_W = 8
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             wr_en_i,
  input  logic [STATE_W-1:0]               wr_sel_i,
  input  field_e                           wr_field_i,
  input  logic [WORD_W-1:0]                wr_data_i,
  input  logic [STATE_W-1:0]               rd_sel_i,
  output state_word_t                      rd_word_o,
  output logic [NUM_COND-1:0][MATCH_W-1:0] rd_mask_o
);
  state_word_t                      word_q [NUM_STATES];
  logic [NUM_COND-1:0][MATCH_W-1:0] mask_q [NUM_STATES];

  for (genvar g = 0; g < NUM_STATES; g++) begin : g_entry
    logic sel;
    assign sel = wr_en_i && (wr_sel_i == STATE_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        word_q[g] <= '0;
        mask_q[g] <= '0;
      end else if (sel) begin
        unique case (wr_field_i)
          FLD_CTRL: word_q[g]           <= state_word_t'(wr_data_i);
          FLD_CAP:  mask_q[g][COND_CAP]  <= wr_data_i[MATCH_W-1:0];
          FLD_HIT:  mask_q[g][COND_HIT]  <= wr_data_i[MATCH_W-1:0];
          FLD_ELSE: mask_q[g][COND_ELSE] <= wr_data_i[MATCH_W-1:0];
          default: ;
        endcase
      end
    end
  end

  assign rd_word_o = word_q[rd_sel_i];
  assign rd_mask_o = mask_q[rd_sel_i];
endmodule

// File: rtl/trig_seq_core.sv
module trig_seq_core
  import trig_seq_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                arm_i,
  input  logic                sample_valid_i,
  input  logic [NUM_COND-1:0] cond_i,
  input  state_word_t         word_i,
  output logic [STATE_W-1:0]  state_o,
  output logic                capture_o,
  output logic                run_o,
  output logic [NUM_TMR-1:0]  tmr_start_o,
  output logic [NUM_TMR-1:0]  tmr_stop_o,
  output logic [NUM_TMR-1:0]  tmr_clear_o
);
  localparam logic [STATE_W-1:0] LAST_IDX = STATE_W'(NUM_STATES - 1);

  logic [STATE_W-1:0] state_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W-1:0]   occ_eff;
  logic [CNT_W:0]     cnt_inc;
  logic               done;
  logic               is_last;

  assign occ_eff = (word_i.occ == '0) ? CNT_W'(1) : word_i.occ;
  assign cnt_inc = {1'b0, cnt_q} + (CNT_W+1)'(1);
  assign done    = cnt_inc >= {1'b0, occ_eff};
  assign is_last = word_i.last || (state_q == LAST_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= '0;
      cnt_q       <= '0;
      capture_o   <= 1'b0;
      run_o       <= 1'b0;
      tmr_start_o <= '0;
      tmr_stop_o  <= '0;
      tmr_clear_o <= '0;
    end else if (!arm_i) begin
      state_q     <= '0;
      cnt_q       <= '0;
      capture_o   <= 1'b0;
      run_o       <= 1'b0;
      tmr_start_o <= '0;
      tmr_stop_o  <= '0;
      tmr_clear_o <= '0;
    end else begin
      capture_o   <= sample_valid_i && cond_i[COND_CAP];
      tmr_start_o <= '0;
      tmr_stop_o  <= '0;
      tmr_clear_o <= '0;
      if (sample_valid_i) begin
        if (cond_i[COND_HIT]) begin
          if (done) begin
            cnt_q       <= '0;
            tmr_start_o <= word_i.start;
            tmr_stop_o  <= word_i.stop;
            tmr_clear_o <= word_i.clear;
            if (word_i.trig || is_last) run_o <= 1'b1;
            if (!is_last) state_q <= state_q + STATE_W'(1);
          end else begin
            cnt_q <= cnt_inc[CNT_W-1:0];
          end
        end else if (cond_i[COND_ELSE]) begin
          cnt_q   <= '0;
          state_q <= word_i.else_idx;
        end
      end
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/trig_seq.sv
module trig_seq
  import trig_seq_pkg::*;
#(
  parameter int MATCH_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               arm_i,
  input  logic               wr_en_i,
  input  logic [3:0]         wr_sel_i,
  input  logic [1:0]         wr_field_i,
  input  logic [31:0]        wr_data_i,
  input  logic               sample_valid_i,
  input  logic [MATCH_W-1:0] match_i,
  output logic               capture_o,
  output logic               run_o,
  output logic [1:0]         tmr_start_o,
  output logic [1:0]         tmr_stop_o,
  output logic [1:0]         tmr_clear_o,
  output logic [3:0]         state_o
);
  state_word_t                      cur_word;
  logic [NUM_COND-1:0][MATCH_W-1:0] cur_mask;
  logic [NUM_COND-1:0]              cur_cond;
  logic [STATE_W-1:0]               cur_state;

  // table frozen while armed
  trig_seq_table #(.MATCH_W(MATCH_W)) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i && !arm_i),
    .wr_sel_i   (wr_sel_i),
    .wr_field_i (field_e'(wr_field_i)),
    .wr_data_i  (wr_data_i),
    .rd_sel_i   (cur_state),
    .rd_word_o  (cur_word),
    .rd_mask_o  (cur_mask)
  );

  trig_seq_cond #(.MATCH_W(MATCH_W), .NUM_COND(NUM_COND)) u_cond (
    .mask_i  (cur_mask),
    .match_i (match_i),
    .cond_o  (cur_cond)
  );

  trig_seq_core u_core (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .arm_i          (arm_i),
    .sample_valid_i (sample_valid_i),
    .cond_i         (cur_cond),
    .word_i         (cur_word),
    .state_o        (cur_state),
    .capture_o      (capture_o),
    .run_o          (run_o),
    .tmr_start_o    (tmr_start_o),
    .tmr_stop_o     (tmr_stop_o),
    .tmr_clear_o    (tmr_clear_o)
  );

  assign state_o = cur_state;
endmodule

// File: rtl/trig_seq_chk.sv
module trig_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       arm_i,
  input logic       sample_valid_i,
  input logic       capture_o,
  input logic       run_o,
  input logic [1:0] tmr_start_o,
  input logic [1:0] tmr_stop_o,
  input logic [1:0] tmr_clear_o,
  input logic [3:0] state_o
);
  logic [5:0] pulses;
  assign pulses = {tmr_start_o, tmr_clear_o, tmr_stop_o};

  // R2
  disarm_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_i |=> (state_o == 4'd0) && !run_o && !capture_o && (pulses == 6'd0));

  // R3
  idle_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_i && !sample_valid_i) |=> $stable(state_o) && !capture_o && (pulses == 6'd0));

  // R4
  capture_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_o |-> $past(arm_i && sample_valid_i));

  // R6
  pulse_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulses != 6'd0) |-> $past(arm_i && sample_valid_i));

  // R7
  run_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && arm_i) |=> run_o);

  // R5
  state_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(state_o) |-> $past(sample_valid_i || !arm_i));
endmodule

bind trig_seq trig_seq_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .arm_i          (arm_i),
  .sample_valid_i (sample_valid_i),
  .capture_o      (capture_o),
  .run_o          (run_o),
  .tmr_start_o    (tmr_start_o),
  .tmr_stop_o     (tmr_stop_o),
  .tmr_clear_o    (tmr_clear_o),
  .state_o        (state_o)
);

// File: tb/trig_seq_bench.sv
module trig_seq_bench;
  localparam int MATCH_W = 8;
  localparam int NVEC    = 10;

  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic               arm_i = 1'b0;
  logic               wr_en_i = 1'b0;
  logic [3:0]         wr_sel_i = '0;
  logic [1:0]         wr_field_i = '0;
  logic [31:0]        wr_data_i = '0;
  logic               sample_valid_i = 1'b0;
  logic [MATCH_W-1:0] match_i = '0;
  logic               capture_o, run_o;
  logic [1:0]         tmr_start_o, tmr_stop_o, tmr_clear_o;
  logic [3:0]         state_o;

  int total = 0;
  int bad   = 0;

  always #10 clk_i = ~clk_i;

  trig_seq #(.MATCH_W(MATCH_W)) u_trig_seq (.*);

  // {valid, match[7:0], cap, state[3:0], run, pulses{start,clear,stop}}
  localparam logic [20:0] VEC [NVEC] = '{
    {1'b0, 8'h01, 1'b0, 4'd0, 1'b0, 6'h00},
    {1'b1, 8'h81, 1'b1, 4'd0, 1'b0, 6'h00},
    {1'b1, 8'h01, 1'b0, 4'd1, 1'b0, 6'h10},
    {1'b1, 8'h04, 1'b0, 4'd0, 1'b0, 6'h00},
    {1'b1, 8'h01, 1'b0, 4'd0, 1'b0, 6'h00},
    {1'b1, 8'h00, 1'b0, 4'd0, 1'b0, 6'h00},
    {1'b1, 8'h01, 1'b0, 4'd1, 1'b0, 6'h10},
    {1'b1, 8'h06, 1'b0, 4'd2, 1'b1, 6'h02},
    {1'b1, 8'h08, 1'b1, 4'd2, 1'b1, 6'h00},
    {1'b1, 8'h10, 1'b0, 4'd1, 1'b1, 6'h00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] sel, input logic [1:0] fld, input logic [31:0] data);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_field_i = fld; wr_data_i = data;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic samp(input logic v, input logic [MATCH_W-1:0] m);
    sample_valid_i = v; match_i = m;
    @(negedge clk_i);
    sample_valid_i = 1'b0; match_i = '0;
  endtask

  task automatic set_arm(input logic a);
    arm_i = a;
    @(negedge clk_i);
  endtask

  function automatic logic [5:0] pul();
    return {tmr_start_o, tmr_clear_o, tmr_stop_o};
  endfunction

  initial begin
    repeat (100000) @(posedge clk_i);
    bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 state", 32'(state_o), 0);
    chk("R1 run", 32'(run_o), 0);
    chk("R1 capture", 32'(capture_o), 0);
    chk("R1 pulses", 32'(pul()), 0);

    // state 0: occ 2, start timer0
    wr(4'd0, 2'd0, 32'h1000_0002); wr(4'd0, 2'd1, 32'h80); wr(4'd0, 2'd2, 32'h01);
    // state 1: occ 0, trigger, stop timer1, else -> 0
    wr(4'd1, 2'd0, 32'h4200_0000); wr(4'd1, 2'd2, 32'h02); wr(4'd1, 2'd3, 32'h04);
    // state 2: occ 3, last, clear timer0, else -> 1
    wr(4'd2, 2'd0, 32'h8410_0003); wr(4'd2, 2'd1, 32'h08); wr(4'd2, 2'd2, 32'h08);
    wr(4'd2, 2'd3, 32'h10);
    set_arm(1'b1);

    // R3 R4 R5 R6 R7 R9 table walk
    for (int i = 0; i < NVEC; i++) begin
      samp(VEC[i][20], VEC[i][19:12]);
      chk("R4 capture", 32'(capture_o), 32'(VEC[i][11]));
      chk("R5 R9 state", 32'(state_o), 32'(VEC[i][10:7]));
      chk("R7 run", 32'(run_o), 32'(VEC[i][6]));
      chk("R6 pulses", 32'(pul()), 32'(VEC[i][5:0]));
    end

    // R2: write while armed is dropped
    wr(4'd0, 2'd2, 32'h00);
    set_arm(1'b0);
    chk("R2 disarm state", 32'(state_o), 0);
    chk("R2 R7 disarm run", 32'(run_o), 0);
    set_arm(1'b1);
    samp(1'b1, 8'h01);
    chk("R2 first hit", 32'(state_o), 0);
    samp(1'b1, 8'h01);
    chk("R2 hit mask kept", 32'(state_o), 1);
    chk("R6 start pulse", 32'(pul()), 32'h10);

    // R8: marked last state holds index
    set_arm(1'b0);
    wr(4'd1, 2'd0, 32'h0000_0000);
    set_arm(1'b1);
    samp(1'b1, 8'h01); samp(1'b1, 8'h01);
    samp(1'b1, 8'h02);
    chk("R5 occ zero advance", 32'(state_o), 2);
    chk("R7 no trigger flag", 32'(run_o), 0);
    samp(1'b1, 8'h08); samp(1'b1, 8'h08);
    chk("R5 before count", 32'(run_o), 0);
    samp(1'b1, 8'h08);
    chk("R8 last holds", 32'(state_o), 2);
    chk("R7 last runs", 32'(run_o), 1);
    chk("R6 clear pulse", 32'(pul()), 32'h04);
    samp(1'b1, 8'h08);
    chk("R8 count cleared", 32'(run_o), 1);
    chk("R6 pulse one cycle", 32'(pul()), 0);

    // R10 empty hit mask; R8 state 15 implicit last
    set_arm(1'b0);
    wr(4'd0, 2'd2, 32'h00);
    wr(4'd0, 2'd0, 32'h10F0_0002);
    wr(4'd0, 2'd3, 32'h40);
    wr(4'd15, 2'd0, 32'h0000_0001);
    wr(4'd15, 2'd2, 32'h01);
    set_arm(1'b1);
    samp(1'b1, 8'hBF);
    chk("R10 empty mask", 32'(state_o), 0);
    chk("R4 capture w/o hit", 32'(capture_o), 1);
    samp(1'b1, 8'h40);
    chk("R9 else to 15", 32'(state_o), 15);
    samp(1'b1, 8'h01);
    chk("R8 top state run", 32'(run_o), 1);
    chk("R8 top state hold", 32'(state_o), 15);
    samp(1'b0, 8'hFF);
    chk("R3 idle capture", 32'(capture_o), 0);
    chk("R3 idle state", 32'(state_o), 15);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule